// File: doc/BRIEF.md
# DMA Address Update Unit

This block keeps the running source or destination address for one DMA channel. It moves that address forward after every transferred word. A load port sets four things at once: the start address, a signed step offset, a modifier code and a region flag. After that, each update strobe replaces the held address with the next one. The new value is visible on the output one clock after the strobe.

The modifier code picks the update mode:

- **Linear:** the offset is added to the address.
- **Modulo:** the address stays inside a circular buffer.
- **Bit-reverse:** the offset is added with the carry running from high bits toward low bits. This produces the scrambled order used by FFT buffers.

The region flag controls what happens after the mode arithmetic:

- **Internal:** the result is folded back into the on-chip space, which runs from 0 to `INT_TOP`.
- **External:** the result is passed through unchanged, even when it lands below the lowest external address.

A block must lie wholly inside one region. Software splits any block that would straddle the two regions.

Top module: `dma_addr_update`

## Requirements
- R1: After reset the address output is 0, the offset is 0, the modifier is all ones (linear) and the region is internal.
- R2: When `load` is high, the next clock stores `ld_addr`, `ld_off`, `ld_mod` and `ld_ext`, and `addr_q` equals `ld_addr` one cycle later. A simultaneous `step` is ignored.
- R3: With modifier 0xFFFF (linear), each `step` makes `addr_q` equal to the previous address plus the offset, one cycle after the strobe. The offset is a two's-complement value and the sum wraps at 32 bits.
- R4: With offset 0 in linear or bit-reverse mode, a `step` leaves `addr_q` unchanged. This is how a fixed peripheral address is repeated.
- R5: Without `load` or `step`, `addr_q` holds its value.
- R6: A modifier M in 1..0x7FFF selects modulo mode with buffer size M+1.
  - The buffer base is the address with its low k bits cleared, where 2^k is the smallest power of two not below M+1.
  - Bits above the low k never change during a modulo step.
  - A position that rises past M wraps to (position − (M+1)).
- R7: In modulo mode, a position that falls below 0 wraps to (position + M+1), that is, toward the top of the buffer.
- R8: Modifier 0 selects bit-reverse mode. Address and offset are treated as unsigned and added with the carry propagating from bit 31 toward bit 0. A carry out of bit 0 is dropped. Example: offset 4 from address 0 visits 0, 4, 2, 6, 1, 5, 3, 7, 0.
- R9: With the region flag 0 (internal), every updated address is reduced modulo `INT_TOP`+1. `INT_TOP`+1 must be a power of two; the default gives 0..0x3FF. This applies to results above `INT_TOP` and to results below 0.
- R10: With the region flag 1 (external), the updated address is used unchanged, including values below `INT_TOP`+1.
- R11: Modifier codes 0x8000..0xFFFE behave as linear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load address, offset, modifier and region |
| ld_addr | input | 32 | Start address to load |
| ld_off | input | 32 | Signed step offset to load |
| ld_mod | input | 16 | Modifier code to load |
| ld_ext | input | 1 | Region to load: 1 external, 0 internal |
| step | input | 1 | Update strobe, one per transferred word |
| addr_q | output | 32 | Current channel address |

## Verification
The assertions check four properties on every cycle:

- the load priority and the hold behaviour;
- that an internal-region update never leaves 0..`INT_TOP`;
- that a zero offset in linear or bit-reverse mode freezes an external address;
- that a modulo step never disturbs the bits above the buffer field.

The exact values need the bench's scenarios:

- the wrap points of odd-sized circular buffers in both directions;
- the bit-reverse visiting order;
- the fold of an internal address that runs past `INT_TOP` or below zero;
- the uncorrected external address just below the internal top.

// File: rtl/dma_agu_pkg.sv
package dma_agu_pkg;

  // Address update mode decoded from the modifier code.
  typedef enum logic [1:0] {
    UPD_LIN = 2'd0,
    UPD_MOD = 2'd1,
    UPD_REV = 2'd2
  } upd_mode_e;

endpackage

// File: rtl/agu_mode_decode.sv
module agu_mode_decode
  import dma_agu_pkg::*;
#(
  parameter int MW = 16
) (
  input  logic [MW-1:0] mod_i,
  output upd_mode_e     mode_o,
  output logic [MW-1:0] span_o
);

  // Mask of all bits up to the highest set bit: 2^k-1 with 2^k >= M+1.
  function automatic logic [MW-1:0] smear(input logic [MW-1:0] v);
    logic [MW-1:0] r;
    r = v;
    for (int i = 1; i < MW; i++) r = r | (r >> i);
    return r;
  endfunction

  always_comb begin
    if (&mod_i)             mode_o = UPD_LIN;
    else if (mod_i == '0)   mode_o = UPD_REV;
    else if (!mod_i[MW-1])  mode_o = UPD_MOD;
    else                    mode_o = UPD_LIN;  // reserved codes
  end

  assign span_o = smear(mod_i);

endmodule

// File: rtl/agu_step_calc.sv
module agu_step_calc
  import dma_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] off_i,
  input  upd_mode_e     mode_i,
  input  logic [MW-1:0] mod_i,
  input  logic [MW-1:0] span_i,
  output logic [AW-1:0] raw_o
);

  localparam int SW = AW + 1;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  // Reverse-carry add: carries travel from the top bit toward bit 0.
  function automatic logic [AW-1:0] rev_add(input logic [AW-1:0] a,
                                            input logic [AW-1:0] b);
    return flip(flip(a) + flip(b));
  endfunction

  // Circular-buffer update inside a power-of-two aligned block.
  function automatic logic [AW-1:0] ring_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b,
                                             input logic [MW-1:0] m,
                                             input logic [MW-1:0] sp);
    logic [AW-1:0]        spw;
    logic signed [SW-1:0] top, pos;
    spw = {{(AW-MW){1'b0}}, sp};
    top = $signed({{(SW-MW){1'b0}}, m});
    pos = $signed({1'b0, a & spw}) + $signed({b[AW-1], b});
    if (pos > top)        pos = pos - (top + 1);
    else if (pos < 0)     pos = pos + (top + 1);
    return (a & ~spw) | (AW'(pos) & spw);
  endfunction

  always_comb begin
    unique case (mode_i)
      UPD_MOD: raw_o = ring_add(addr_i, off_i, mod_i, span_i);
      UPD_REV: raw_o = rev_add(addr_i, off_i);
      default: raw_o = addr_i + off_i;
    endcase
  end

endmodule

// File: rtl/agu_region_fold.sv
module agu_region_fold #(
  parameter int AW      = 32,
  parameter int INT_TOP = 32'h3FF
) (
  input  logic [AW-1:0] raw_i,
  input  logic          ext_i,
  output logic [AW-1:0] fold_o
);

  // INT_TOP+1 is a power of two, so folding is a mask.
  localparam logic [AW-1:0] INT_MASK = AW'(INT_TOP);

  assign fold_o = ext_i ? raw_i : (raw_i & INT_MASK);

endmodule

// File: rtl/dma_addr_update.sv
module dma_addr_update
  import dma_agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MW      = 16,
  parameter int INT_TOP = 32'h3FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] ld_off,
  input  logic [MW-1:0] ld_mod,
  input  logic          ld_ext,
  input  logic          step,
  output logic [AW-1:0] addr_q
);

  localparam logic [MW-1:0] MOD_LINEAR = '1;

  logic [AW-1:0] addr_r, off_r;
  logic [MW-1:0] mod_r;
  logic          ext_r;

  // Named internal events for the checker.
  upd_mode_e     mode_w;
  logic [MW-1:0] span_w;
  logic [AW-1:0] raw_w, next_w;

  agu_mode_decode #(.MW(MW)) u_dec (
    .mod_i  (mod_r),
    .mode_o (mode_w),
    .span_o (span_w)
  );

  agu_step_calc #(.AW(AW), .MW(MW)) u_calc (
    .addr_i (addr_r),
    .off_i  (off_r),
    .mode_i (mode_w),
    .mod_i  (mod_r),
    .span_i (span_w),
    .raw_o  (raw_w)
  );

  agu_region_fold #(.AW(AW), .INT_TOP(INT_TOP)) u_fold (
    .raw_i  (raw_w),
    .ext_i  (ext_r),
    .fold_o (next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0;
      off_r  <= '0;
      mod_r  <= MOD_LINEAR;
      ext_r  <= 1'b0;
    end else if (load) begin
      addr_r <= ld_addr;
      off_r  <= ld_off;
      mod_r  <= ld_mod;
      ext_r  <= ld_ext;
    end else if (step) begin
      addr_r <= next_w;
    end
  end

  assign addr_q = addr_r;

endmodule

// File: rtl/dma_addr_update_chk.sv
module dma_addr_update_chk
  import dma_agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MW      = 16,
  parameter int INT_TOP = 32'h3FF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          step,
  input logic [AW-1:0] ld_addr,
  input logic [AW-1:0] addr_q,
  input logic [AW-1:0] off_q,
  input logic          ext_q,
  input upd_mode_e     mode,
  input logic [MW-1:0] span
);

  localparam logic [AW-1:0] INT_MASK = AW'(INT_TOP);

  logic [AW-1:0] span_x;
  assign span_x = {{(AW-MW){1'b0}}, span};

  a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_q == $past(ld_addr));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(addr_q));

  a_r9_internal_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && !ext_q) |=> addr_q <= INT_MASK);

  a_r4_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && ext_q && off_q == '0 && mode != UPD_MOD) |=> $stable(addr_q));

  a_r6_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && ext_q && mode == UPD_MOD)
      |=> ((addr_q ^ $past(addr_q)) & ~$past(span_x)) == '0);

endmodule

bind dma_addr_update dma_addr_update_chk #(
  .AW(AW), .MW(MW), .INT_TOP(INT_TOP)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load    (load),
  .step    (step),
  .ld_addr (ld_addr),
  .addr_q  (addr_q),
  .off_q   (off_r),
  .ext_q   (ext_r),
  .mode    (mode_w),
  .span    (span_w)
);

// File: tb/sim_dma_addr_update.sv
module sim_dma_addr_update;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [31:0] ld_off = '0;
  logic [15:0] ld_mod = '0;
  logic        ld_ext = 1'b0;
  logic        step = 1'b0;
  logic [31:0] addr_q;

  dma_addr_update u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr),
    .ld_off(ld_off), .ld_mod(ld_mod), .ld_ext(ld_ext), .step(step),
    .addr_q(addr_q)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic [31:0] m_addr, m_off;
  logic [15:0] m_mod;
  logic        m_ext;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;
  logic        done = 1'b0;

  function automatic logic [31:0] model_next(logic [31:0] a, logic [31:0] o,
                                             logic [15:0] m, logic e);
    logic [31:0] r;
    if (m == 16'hFFFF || m[15]) begin
      r = a + o;
    end else if (m == 16'h0000) begin
      logic c;
      c = 1'b0;
      for (int i = 31; i >= 0; i--) begin
        r[i] = a[i] ^ o[i] ^ c;
        c = (a[i] & o[i]) | (c & (a[i] ^ o[i]));
      end
    end else begin
      longint size, p, rel, n;
      size = longint'(m) + 1;
      p = 1;
      while (p < size) p = p * 2;
      rel = longint'(a) % p;
      n = rel + longint'($signed(o));
      if (n > longint'(m)) n = n - size;
      else if (n < 0) n = n + size;
      r = 32'(longint'(a) - rel + n);
    end
    if (!e) r = r % 32'h400;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: addr_q=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(logic [31:0] a, logic [31:0] o, logic [15:0] m,
                         logic e, string tag);
    @(negedge clk);
    load = 1'b1; ld_addr = a; ld_off = o; ld_mod = m; ld_ext = e;
    m_addr = a; m_off = o; m_mod = m; m_ext = e;
    exp_q.push_back(a); tag_q.push_back(tag);
    @(posedge clk); #1;
    load = 1'b0;
  endtask

  // R2: load together with step, step is ignored
  task automatic do_both(logic [31:0] a, logic [31:0] o, logic [15:0] m,
                         logic e);
    @(negedge clk);
    load = 1'b1; step = 1'b1; ld_addr = a; ld_off = o; ld_mod = m; ld_ext = e;
    m_addr = a; m_off = o; m_mod = m; m_ext = e;
    exp_q.push_back(a); tag_q.push_back("R2");
    @(posedge clk); #1;
    load = 1'b0; step = 1'b0;
  endtask

  task automatic do_step(string tag, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      step = 1'b1;
      m_addr = model_next(m_addr, m_off, m_mod, m_ext);
      exp_q.push_back(m_addr); tag_q.push_back(tag);
      @(posedge clk); #1;
      step = 1'b0;
    end
  endtask

  // Monitor: scoreboard pop one cycle after each load/step
  always @(posedge clk) pend <= load | step;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: addr_q=%h expected none", addr_q);
      end else begin
        check(tag_q.pop_front(), addr_q, exp_q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: addr_q=%h expected finish", addr_q);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", addr_q, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", addr_q, 32'h0);
    // R1: reset offset 0, linear, internal: a step keeps 0
    m_addr = 0; m_off = 0; m_mod = 16'hFFFF; m_ext = 0;
    do_step("R1", 1);

    do_load(32'h1000, 32'd4, 16'hFFFF, 1'b1, "R2");
    do_step("R3", 4);
    do_load(32'h2000, 32'hFFFF_FFF0, 16'hFFFF, 1'b1, "R2");
    do_step("R3", 2);

    do_load(32'h0000_8000, 32'd0, 16'hFFFF, 1'b1, "R2");
    do_step("R4", 3);
    do_load(32'h0000_8000, 32'd0, 16'h0000, 1'b1, "R2");
    do_step("R4", 2);

    repeat (3) @(negedge clk);
    check("R5", addr_q, m_addr);
    repeat (2) @(negedge clk);
    check("R5", addr_q, 32'h0000_8000);

    do_both(32'h0000_5000, 32'd8, 16'hFFFF, 1'b1);
    repeat (2) @(negedge clk);
    check("R2", addr_q, 32'h0000_5000);

    // R6: size 5 buffer at 0x100, offset 3; size 8 buffer offset 1
    do_load(32'h0000_0100, 32'd3, 16'd4, 1'b1, "R2");
    do_step("R6", 6);
    do_load(32'h0000_2040, 32'd1, 16'd7, 1'b1, "R2");
    do_step("R6", 9);
    repeat (2) @(negedge clk);
    check("R6", addr_q, 32'h0000_2041);

    // R7: downward wrap
    do_load(32'h0000_2042, 32'hFFFF_FFFE, 16'd7, 1'b1, "R2");
    do_step("R7", 4);
    do_load(32'h0000_0300, 32'hFFFF_FFFD, 16'd9, 1'b0, "R2");
    do_step("R7", 5);

    // R8: bit-reverse order
    do_load(32'h0, 32'd4, 16'h0000, 1'b0, "R2");
    do_step("R8", 8);
    repeat (2) @(negedge clk);
    check("R8", addr_q, 32'h0);
    do_load(32'h0000_5000, 32'h10, 16'h0000, 1'b1, "R2");
    do_step("R8", 5);

    // R9: internal fold up and down
    do_load(32'h0000_03FC, 32'd8, 16'hFFFF, 1'b0, "R2");
    do_step("R9", 2);
    repeat (2) @(negedge clk);
    check("R9", addr_q, 32'h0000_000C);
    do_load(32'h0000_0002, 32'hFFFF_FFFC, 16'hFFFF, 1'b0, "R2");
    do_step("R9", 1);
    repeat (2) @(negedge clk);
    check("R9", addr_q, 32'h0000_03FE);

    // R10: external passes below the internal top
    do_load(32'h0000_0404, 32'hFFFF_FFF8, 16'hFFFF, 1'b1, "R2");
    do_step("R10", 2);
    repeat (2) @(negedge clk);
    check("R10", addr_q, 32'h0000_03F4);

    // R11: reserved modifier codes act linear
    do_load(32'h0000_0010, 32'd2, 16'h8001, 1'b1, "R2");
    do_step("R11", 3);
    do_load(32'h0000_0010, 32'd6, 16'hFFFE, 1'b1, "R2");
    do_step("R11", 2);
    repeat (2) @(negedge clk);
    check("R11", addr_q, 32'h0000_001C);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule